// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Front End

This block is the digital side of a single-channel voltage-output converter that is loaded over a parallel bus. A host drives a data bus, an active-low chip select and an active-low write strobe. The block samples those strobes with its own clock, and on each completed write it captures the bus into an input register. A second register, the DAC register, holds the code that actually drives the converter core. It takes the input register's value only while the active-low load strobe is low. Several such blocks can share one load strobe, so their outputs change together. An active-low clear zeroes both registers at once, with no clock edge needed. The power-down request and the gain-range choice are passed to the core as registered flags.

The code width is a parameter and may be 8, 10 or 12 bits. When the bus is narrower than the code (12-bit code on an 8-bit bus), the code arrives in two writes, and a high-part select input decides which part each write loads. The bus is a plain strobe interface. It has no ready signal and no back-pressure, so every detected write is accepted. The writer must therefore hold the data, chip select and part select steady, and space its writes, for at least STAGES+3 clock cycles after each rising edge of the write strobe.

Top module: `dac_front`

## Requirements
- R1: After power-on reset (rst_n low), code_out is 0 and pd_flag and gain_flag are 0. code_out stays 0 until a write is made and then loaded.
- R2: A write is taken only while cs_n is low. A write strobe with cs_n high leaves the input register unchanged, and a later load presents the old code.
- R3: While ldac_n is high, writes change only the input register. code_out keeps its value.
- R4: While the synchronized ldac_n is low, the DAC register copies the input register on every clock. A load pulse transfers the pending code. With ldac_n held low, each write reaches code_out without a separate load.
- R5: clr_n low asynchronously forces both the input register and the DAC register to zero. code_out reads 0 before the next clock edge, and a following load also gives 0.
- R6: In split mode (BUS_W < CODE_W), a write with hi_sel=0 loads code bits BUS_W-1:0 from the bus. A write with hi_sel=1 loads code bits CODE_W-1:BUS_W from bus bits CODE_W-BUS_W-1:0. The remaining bus bits are ignored, and each write leaves the other part unchanged.
- R7: In full mode (BUS_W >= CODE_W), a single write loads all CODE_W bits from bus bits CODE_W-1:0.
- R8: pd_flag follows pd_in one clock later. Power-down changes neither register, so code_out is unchanged during and after it.
- R9: gain_flag follows gain_in one clock later. A value of 1 selects the doubled output range.
- R10: A write happens on the low-to-high change of the sampled wr_n. Holding wr_n low, or driving it low, captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low asynchronous clear of both registers |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; a write completes on its rising edge |
| ldac_n | input | 1 | Active-low load strobe, input register to DAC register |
| hi_sel | input | 1 | Split mode: 1 writes the high part, 0 writes the low part |
| bus_data | input | BUS_W | Parallel data bus |
| pd_in | input | 1 | Power-down request |
| gain_in | input | 1 | Output range select (1 = doubled range) |
| code_out | output | CODE_W | Code driving the converter core |
| pd_flag | output | 1 | Registered power-down flag |
| gain_flag | output | 1 | Registered gain-range flag |

## Verification
The assertions assume three things about the inputs. First, bus_data and hi_sel are steady from the write strobe's rising edge until the write is registered. Second, every strobe level lasts longer than the synchronizer depth. Third, clr_n, when pulsed, stays low across at least one clock edge, so the hold properties never straddle a clear that came and went between two edges. The bench's driver tasks hold each strobe level for several cycles and keep data, select and chip select fixed for eight cycles around every rising edge of wr_n. They also keep clr_n low for two full cycles, so the stimulus stays within those assumptions. The scoreboard expects a code change only where a load, a transparent-mode write or a clear should cause one. Any other change on code_out counts as a failure.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Kind of write decoded on the cycle a completed write is seen
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_FULL = 2'd1,
    WK_LOW  = 2'd2,
    WK_HIGH = 2'd3
  } wr_kind_t;

  // Split mode is used when the bus cannot carry the whole code
  function automatic bit split_mode(input int code_w, input int bus_w);
    return bus_w < code_w;
  endfunction
endpackage

// File: rtl/dacfe_strobe_sync.sv
module dacfe_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic cs_n,
  input  logic ldac_n,
  output logic wr_event,
  output logic ldac_on
);
  localparam int LAST = STAGES - 1;

  // Bit 0 wr_n, bit 1 cs_n, bit 2 ldac_n; all idle high
  logic [2:0] stage_q [STAGES];
  logic       wr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= 3'b111;
      wr_prev_q <= 1'b1;
    end else begin
      stage_q[0] <= {ldac_n, cs_n, wr_n};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      wr_prev_q <= stage_q[LAST][0];
    end
  end

  // Completed write: sampled strobe rose while sampled select is low
  assign wr_event = stage_q[LAST][0] & ~wr_prev_q & ~stage_q[LAST][1];
  assign ldac_on  = ~stage_q[LAST][2];

  // R10: a completed write is a single-cycle event
  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |=> !wr_event);
endmodule

// File: rtl/dacfe_input_reg.sv
module dacfe_input_reg
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              areset_n,
  input  logic              wr_event,
  input  logic              hi_sel,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [CODE_W-1:0] in_q
);
  wr_kind_t kind;

  if (!split_mode(CODE_W, BUS_W)) begin : g_full
    assign kind = wr_event ? WK_FULL : WK_NONE;

    always_ff @(posedge clk or negedge areset_n) begin
      if (!areset_n)           in_q <= '0;
      else if (kind == WK_FULL) in_q <= bus_data[CODE_W-1:0];
    end

    // R7: a full write lands the whole bus word
    a_r7_full_load: assert property (@(posedge clk) disable iff (!areset_n)
      wr_event |=> in_q == $past(bus_data[CODE_W-1:0]));
  end else begin : g_split
    localparam int HI_W = CODE_W - BUS_W;
    logic [BUS_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;

    always_comb begin
      if (!wr_event)   kind = WK_NONE;
      else if (hi_sel) kind = WK_HIGH;
      else             kind = WK_LOW;
    end

    always_ff @(posedge clk or negedge areset_n) begin
      if (!areset_n)           lo_q <= '0;
      else if (kind == WK_LOW) lo_q <= bus_data;
    end

    always_ff @(posedge clk or negedge areset_n) begin
      if (!areset_n)            hi_q <= '0;
      else if (kind == WK_HIGH) hi_q <= bus_data[HI_W-1:0];
    end

    assign in_q = {hi_q, lo_q};

    // R6: each part write leaves the other part untouched
    a_r6_low_keeps_high: assert property (@(posedge clk) disable iff (!areset_n)
      (wr_event && !hi_sel) |=> $stable(in_q[CODE_W-1:BUS_W]));
    a_r6_high_keeps_low: assert property (@(posedge clk) disable iff (!areset_n)
      (wr_event && hi_sel) |=> $stable(in_q[BUS_W-1:0]));
    a_r6_high_source: assert property (@(posedge clk) disable iff (!areset_n)
      (wr_event && hi_sel) |=> in_q[CODE_W-1:BUS_W] == $past(bus_data[HI_W-1:0]));
  end

  // R2 / R10: without a completed write the input register holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!areset_n)
    !wr_event |=> $stable(in_q));
endmodule

// File: rtl/dacfe_dac_reg.sv
module dacfe_dac_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              areset_n,
  input  logic              load,
  input  logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q
);
  always_ff @(posedge clk or negedge areset_n) begin
    if (!areset_n) dac_q <= '0;
    else if (load) dac_q <= in_q;
  end

  // R3: no load, no change at the converter
  a_r3_dac_hold: assert property (@(posedge clk) disable iff (!areset_n)
    !load |=> $stable(dac_q));
  // R4: a load cycle copies the input register
  a_r4_transfer: assert property (@(posedge clk) disable iff (!areset_n)
    load |=> dac_q == $past(in_q));
endmodule

// File: rtl/dac_front.sv
module dac_front #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ldac_n,
  input  logic              hi_sel,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              pd_in,
  input  logic              gain_in,
  output logic [CODE_W-1:0] code_out,
  output logic              pd_flag,
  output logic              gain_flag
);
  logic              wr_event;
  logic              ldac_on;
  logic              reg_rst_n;
  logic [CODE_W-1:0] in_q;

  // Either power-on reset or clear empties both code registers
  assign reg_rst_n = rst_n & clr_n;

  dacfe_strobe_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .cs_n     (cs_n),
    .ldac_n   (ldac_n),
    .wr_event (wr_event),
    .ldac_on  (ldac_on)
  );

  dacfe_input_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_in (
    .clk      (clk),
    .areset_n (reg_rst_n),
    .wr_event (wr_event),
    .hi_sel   (hi_sel),
    .bus_data (bus_data),
    .in_q     (in_q)
  );

  dacfe_dac_reg #(.CODE_W(CODE_W)) u_dac (
    .clk      (clk),
    .areset_n (reg_rst_n),
    .load     (ldac_on),
    .in_q     (in_q),
    .dac_q    (code_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_flag   <= 1'b0;
      gain_flag <= 1'b0;
    end else begin
      pd_flag   <= pd_in;
      gain_flag <= gain_in;
    end
  end

  // R8: power-down flag tracks its request one cycle late
  a_r8_pd_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pd_flag == $past(pd_in));
  // R9: gain flag tracks its select one cycle late
  a_r9_gain_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gain_flag == $past(gain_in));
  // R5: clear held low means a zero code
  a_r5_clear_zero: assert property (@(posedge clk)
    !clr_n |-> code_out == '0);
endmodule

// File: tb/dac_front_bench.sv
module dac_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ldac_n = 1'b1;
  logic        hi_sel = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [9:0]  w_bus = '0;
  logic        pd_in = 1'b0;
  logic        gain_in = 1'b0;
  logic [11:0] code;
  logic [9:0]  w_code;
  logic        pd_flag, gain_flag, w_pd, w_gain;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_en = 0;

  logic [11:0] exp_q [$];
  string       tag_q [$];
  logic [11:0] in_m = '0;
  logic [11:0] dac_m = '0;
  bit          ldac_low = 0;
  logic [11:0] last_code = '0;

  always #5 clk = ~clk;

  dac_front u_dac_front (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .ldac_n(ldac_n), .hi_sel(hi_sel), .bus_data(bus_data), .pd_in(pd_in),
    .gain_in(gain_in), .code_out(code), .pd_flag(pd_flag), .gain_flag(gain_flag)
  );

  dac_front #(.CODE_W(10), .BUS_W(10)) u_dac_front_wide (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .ldac_n(ldac_n), .hi_sel(1'b0), .bus_data(w_bus), .pd_in(pd_in),
    .gain_in(gain_in), .code_out(w_code), .pd_flag(w_pd), .gain_flag(w_gain)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [11:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: every code change must match the next expected item
  always @(negedge clk) begin : monitor
    logic [11:0] e;
    string t;
    if (mon_en && code !== last_code) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected code change actual=%h expected=%h", code, last_code);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (code !== e) begin
          fails++;
          $display("FAIL %s code actual=%h expected=%h", t, code, e);
        end
      end
      last_code = code;
    end
  end

  task automatic model_write(input logic [7:0] d, input bit hi, input string tag);
    if (hi) in_m[11:8] = d[3:0];
    else    in_m[7:0]  = d;
    if (ldac_low && in_m != dac_m) begin
      dac_m = in_m;
      push(dac_m, tag);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input bit hi, input bit sel, input string tag);
    bus_data = d;
    hi_sel   = hi;
    cs_n     = !sel;
    tick(2);
    wr_n = 1'b0;
    tick(3);
    wr_n = 1'b1;
    if (sel) model_write(d, hi, tag);
    tick(8);
    cs_n = 1'b1;
    tick(2);
  endtask

  task automatic pulse_ldac(input string tag);
    if (in_m != dac_m) begin
      dac_m = in_m;
      push(dac_m, tag);
    end
    ldac_n = 1'b0;
    tick(4);
    ldac_n = 1'b1;
    tick(5);
  endtask

  task automatic hold_ldac(input bit low, input string tag);
    ldac_low = low;
    if (low && in_m != dac_m) begin
      dac_m = in_m;
      push(dac_m, tag);
    end
    ldac_n = !low;
    tick(5);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset code", code, 12'h000);
    chk("R1 reset pd_flag", pd_flag, 1'b0);
    chk("R1 reset gain_flag", gain_flag, 1'b0);
    mon_en = 1;

    // R6 split writes, R3 no output change without load
    w_bus = 10'h2B7;
    do_write(8'hA5, 1'b0, 1'b1, "R6");
    chk("R3 code after low write", code, 12'h000);
    w_bus = 10'h155;
    do_write(8'hF3, 1'b1, 1'b1, "R6");
    chk("R3 code after high write", code, 12'h000);
    chk("R3 wide code before load", w_code, 10'h000);
    pulse_ldac("R4 load pulse");
    chk("R4 code after load", code, 12'h3A5);
    chk("R7 wide full-width load", w_code, 10'h155);

    // R2 write ignored without chip select
    w_bus = 10'h0AA;
    do_write(8'h11, 1'b0, 1'b0, "R2");
    pulse_ldac("R2 load");
    chk("R2 code unchanged", code, 12'h3A5);
    chk("R2 wide unchanged", w_code, 10'h155);

    // R4 transparent mode with R10 edge detection
    hold_ldac(1'b1, "R4 hold");
    bus_data = 8'h5C;
    hi_sel   = 1'b0;
    cs_n     = 1'b0;
    tick(2);
    wr_n = 1'b0;
    tick(8);
    chk("R10 no capture while wr_n low", code, 12'h3A5);
    wr_n = 1'b1;
    model_write(8'h5C, 1'b0, "R10 capture on rise");
    tick(8);
    cs_n = 1'b1;
    chk("R4 transparent low write", code, 12'h35C);
    do_write(8'hAA, 1'b1, 1'b1, "R6 transparent high");
    chk("R6 upper bus bits ignored", code, 12'hA5C);

    // R8 power-down
    pd_in = 1'b1;
    tick(3);
    chk("R8 pd_flag set", pd_flag, 1'b1);
    chk("R8 code kept in power-down", code, 12'hA5C);
    pd_in = 1'b0;
    tick(3);
    chk("R8 pd_flag clear", pd_flag, 1'b0);
    chk("R8 code resumes", code, 12'hA5C);

    // R9 gain select
    gain_in = 1'b1;
    tick(2);
    chk("R9 gain_flag set", gain_flag, 1'b1);
    gain_in = 1'b0;
    tick(2);
    chk("R9 gain_flag clear", gain_flag, 1'b0);

    // R3 then R5 clear
    hold_ldac(1'b0, "R4 release");
    do_write(8'h12, 1'b0, 1'b1, "R3");
    chk("R3 code held with load high", code, 12'hA5C);
    in_m  = '0;
    dac_m = '0;
    push(12'h000, "R5 clear");
    clr_n = 1'b0;
    #1;
    chk("R5 async clear code", code, 12'h000);
    chk("R5 async clear wide", w_code, 10'h000);
    tick(2);
    clr_n = 1'b1;
    tick(2);
    pulse_ldac("R5 load after clear");
    chk("R5 input register cleared", code, 12'h000);

    tick(3);
    chk("R4 all expected changes seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule